// File: doc/BRIEF.md
# Two-Channel Host Register Bus Front End

This block connects an asynchronous, strobe-driven host bus to the register sets of a two-channel serial controller. The host drives an active-low chip select, active-low read and write strobes, a channel-select level and a 3-bit register address. Each channel owns an eight-entry byte register bank. A write lands in the addressed register when the write strobe returns high. A read puts the addressed byte on the bus for as long as the read strobe and chip select stay low.

One register in each bank is an alternate-function register. Bit 0 of that register turns on broadcast mode. While broadcast mode is on, a single write updates the same address in both channels and the channel-select level is ignored. This is useful when both channels are set up with identical values.

Each channel also drives a registered interrupt request and an active-low transmitter-ready indication from status inputs supplied by the rest of the controller. Strobes and selects cross into the system clock through two-flop synchronizers. Edges are detected on the synchronized copies.

Top module: `dual_chan_host_if`

## Requirements
- R1: Register address `addr[2:0]` selects one of eight independent byte registers per channel; every address of every channel can be written and read back.
- R2: A write is committed only after `wr_n` returns high (at most 3 clock edges later); while `wr_n` is still low the register keeps its old value.
- R3: With `cs_n` held high during a strobe, a write changes no register.
- R4: Without broadcast, `chan_sel` = 1 addresses channel A and `chan_sel` = 0 addresses channel B; a write touches only that channel.
- R5: `bus_oe` is high only while `rd_n` and `cs_n` are both low (seen through a 2-edge synchronizer), and `bus_dout` then carries the addressed register; otherwise `bus_oe` is low.
- R6: Address 7 is the alternate-function register. When bit 0 of it is 1 in either channel, a write with `cs_n` low updates that address in both channels, regardless of `chan_sel`.
- R7: A broadcast write of a byte with bit 0 = 0 to address 7 clears broadcast mode in both channels, and later writes again reach one channel only.
- R8: Reads ignore broadcast mode and return the register of the channel named by `chan_sel`.
- R9: `irq_x` is high one clock edge after `irq_stat_x[3:0] & REG1_x[3:0]` is nonzero, where REG1_x is the register at address 1 of that channel; otherwise it is low.
- R10: `txrdy_n_x` equals the inverse of `tx_ready_x` one clock edge later.
- R11: After reset all registers read 0, broadcast is off, `irq_a`/`irq_b` are low, `txrdy_n_a`/`txrdy_n_b` are low and `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| chan_sel | input | 1 | 1 = channel A, 0 = channel B |
| addr | input | 3 | Register address |
| bus_din | input | 8 | Host data, input half of the bus |
| bus_dout | output | 8 | Read data, output half of the bus |
| bus_oe | output | 1 | Bus driver enable for `bus_dout` |
| irq_stat_a | input | 4 | Interrupt sources of channel A |
| irq_stat_b | input | 4 | Interrupt sources of channel B |
| tx_ready_a | input | 1 | Channel A transmitter can accept data |
| tx_ready_b | input | 1 | Channel B transmitter can accept data |
| irq_a | output | 1 | Channel A interrupt, active high |
| irq_b | output | 1 | Channel B interrupt, active high |
| txrdy_n_a | output | 1 | Channel A transmitter ready, active low |
| txrdy_n_b | output | 1 | Channel B transmitter ready, active low |

## Verification
Bus inputs change on the falling clock edge. The read enable and read data are due two rising edges after `rd_n`, `cs_n` and `chan_sel` settle, and the bench samples them after three. A committed write is due three edges after `wr_n` rises; the bench holds the strobe high for four edges before releasing select and reading back. The interrupt and transmitter-ready outputs are due one edge after their inputs or a register change, and are sampled on the next falling edge, or later when a write commit comes first.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int NUM_CH   = 2;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int STAT_W   = 4;
    localparam int IER_ADDR = 1;
    localparam int AFR_ADDR = 7;
    localparam int SYNC_W   = 4;   // cs, rd, wr, chan_sel
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/hbi_strobe_ctl.sv
module hbi_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ch_s,
    output logic commit,
    output logic commit_ch,
    output logic rd_active
);
    typedef struct packed {
        logic wr_prev;
        logic armed;
        logic ch;
    } stb_st_t;

    stb_st_t st_d, st_q;
    logic    wr_rise;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_s;
        wr_rise      = wr_s && !st_q.wr_prev;
        if (!wr_s && !cs_s && !st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.ch    = ch_s;
        end
        if (wr_rise) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_prev <= 1'b1;
            st_q.armed   <= 1'b0;
            st_q.ch      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit    = wr_rise && st_q.armed;
    assign commit_ch = st_q.ch;
    assign rd_active = !rd_s && !cs_s;
endmodule

// File: rtl/hbi_reg_bank.sv
module hbi_reg_bank
    import hbi_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [SW-1:0] ier,
    output logic          afr_bcast
);
    localparam int NREG = 1 << AW;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.regs[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.regs[rd_addr];
    assign ier       = st_q.regs[IER_ADDR][SW-1:0];
    assign afr_bcast = st_q.regs[AFR_ADDR][0];
endmodule

// File: rtl/hbi_chan_status.sv
module hbi_chan_status
    import hbi_pkg::*;
#(
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] irq_stat,
    input  logic [SW-1:0] ier,
    input  logic          tx_ready,
    output logic          irq,
    output logic          txrdy_n
);
    typedef struct packed {
        logic irq;
        logic txrdy_n;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.irq     = |(irq_stat & ier);
        st_d.txrdy_n = !tx_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq     <= 1'b0;
            st_q.txrdy_n <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign txrdy_n = st_q.txrdy_n;
endmodule

// File: rtl/dual_chan_host_if.sv
module dual_chan_host_if
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              chan_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [STAT_W-1:0] irq_stat_a,
    input  logic [STAT_W-1:0] irq_stat_b,
    input  logic              tx_ready_a,
    input  logic              tx_ready_b,
    output logic              irq_a,
    output logic              irq_b,
    output logic              txrdy_n_a,
    output logic              txrdy_n_b
);
    logic [SYNC_W-1:0] sync_s;
    logic              cs_s, rd_s, wr_s, ch_s;
    logic              commit, commit_ch, rd_active;
    logic              wr_idx, rd_idx, bcast;

    logic [NUM_CH-1:0]             bank_we;
    logic [NUM_CH-1:0]             afr_bit;
    logic [NUM_CH-1:0][DATA_W-1:0] rd_data;
    logic [NUM_CH-1:0][STAT_W-1:0] ier;
    logic [NUM_CH-1:0][STAT_W-1:0] stat_in;
    logic [NUM_CH-1:0]             txr_in;
    logic [NUM_CH-1:0]             irq_out;
    logic [NUM_CH-1:0]             txrdy_out;

    hbi_sync #(.W(SYNC_W), .RST_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({chan_sel, wr_n, rd_n, cs_n}),
        .sync_out (sync_s)
    );

    assign cs_s = sync_s[0];
    assign rd_s = sync_s[1];
    assign wr_s = sync_s[2];
    assign ch_s = sync_s[3];

    hbi_strobe_ctl u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .rd_s      (rd_s),
        .wr_s      (wr_s),
        .ch_s      (ch_s),
        .commit    (commit),
        .commit_ch (commit_ch),
        .rd_active (rd_active)
    );

    // channel index 0 is A (select level 1), index 1 is B (select level 0)
    assign wr_idx = !commit_ch;
    assign rd_idx = !ch_s;
    assign bcast  = |afr_bit;

    assign stat_in = {irq_stat_b, irq_stat_a};
    assign txr_in  = {tx_ready_b, tx_ready_a};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign bank_we[g] = commit && (bcast || (wr_idx == 1'(g)));

        hbi_reg_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (bank_we[g]),
            .wr_addr   (addr),
            .wr_data   (bus_din),
            .rd_addr   (addr),
            .rd_data   (rd_data[g]),
            .ier       (ier[g]),
            .afr_bcast (afr_bit[g])
        );

        hbi_chan_status u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_stat (stat_in[g]),
            .ier      (ier[g]),
            .tx_ready (txr_in[g]),
            .irq      (irq_out[g]),
            .txrdy_n  (txrdy_out[g])
        );
    end

    assign bus_oe    = rd_active;
    assign bus_dout  = rd_active ? rd_data[rd_idx] : '0;
    assign irq_a     = irq_out[0];
    assign irq_b     = irq_out[1];
    assign txrdy_n_a = txrdy_out[0];
    assign txrdy_n_b = txrdy_out[1];
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker
    import hbi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              bus_oe,
    input logic              commit,
    input logic              bcast,
    input logic [NUM_CH-1:0] bank_we,
    input logic [STAT_W-1:0] irq_stat_a,
    input logic [STAT_W-1:0] irq_stat_b,
    input logic              irq_a,
    input logic              irq_b,
    input logic              tx_ready_a,
    input logic              tx_ready_b,
    input logic              txrdy_n_a,
    input logic              txrdy_n_b
);
    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!$past(rd_n, 2) && !$past(cs_n, 2))); // R5
    AST_UNICAST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !bcast) |-> ($countones(bank_we) == 1)); // R4
    AST_BCAST_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bcast) |-> (bank_we == '1)); // R6
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> (bank_we == '0)); // R3
    AST_IRQ_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> $past(irq_stat_a != '0)); // R9
    AST_IRQ_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> $past(irq_stat_b != '0)); // R9
    AST_TXRDY_A_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txrdy_n_a) |-> $past(tx_ready_a)); // R10
    AST_TXRDY_B_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txrdy_n_b) |-> $past(tx_ready_b)); // R10
endmodule

bind dual_chan_host_if hbi_checker u_hbi_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .bus_oe     (bus_oe),
    .commit     (commit),
    .bcast      (bcast),
    .bank_we    (bank_we),
    .irq_stat_a (irq_stat_a),
    .irq_stat_b (irq_stat_b),
    .irq_a      (irq_a),
    .irq_b      (irq_b),
    .tx_ready_a (tx_ready_a),
    .tx_ready_b (tx_ready_b),
    .txrdy_n_a  (txrdy_n_a),
    .txrdy_n_b  (txrdy_n_b)
);

// File: tb/test_dual_chan_host_if.sv
module test_dual_chan_host_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, chan_sel = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic [3:0] irq_stat_a = '0, irq_stat_b = '0;
    logic       tx_ready_a = 1'b0, tx_ready_b = 1'b0;
    logic       irq_a, irq_b, txrdy_n_a, txrdy_n_b;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] mdl [2][8];

    always #4 clk = ~clk;

    dual_chan_host_if i_dual_chan_host_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .chan_sel(chan_sel), .addr(addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe),
        .irq_stat_a(irq_stat_a), .irq_stat_b(irq_stat_b),
        .tx_ready_a(tx_ready_a), .tx_ready_b(tx_ready_b),
        .irq_a(irq_a), .irq_b(irq_b), .txrdy_n_a(txrdy_n_a), .txrdy_n_b(txrdy_n_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int idx_of(input logic ch);
        return ch ? 0 : 1;
    endfunction

    function automatic logic bcast_on();
        return mdl[0][7][0] | mdl[1][7][0];
    endfunction

    function automatic logic exp_irq(input int c, input logic [3:0] st);
        return |(st & mdl[c][1][3:0]);
    endfunction

    task automatic model_write(input logic cs, input logic ch, input logic [2:0] a,
                               input logic [7:0] d);
        if (!cs) begin
            if (bcast_on()) begin
                mdl[0][a] = d;
                mdl[1][a] = d;
            end else begin
                mdl[idx_of(ch)][a] = d;
            end
        end
    endtask

    task automatic bus_write(input logic cs, input logic ch, input logic [2:0] a,
                             input logic [7:0] d);
        @(negedge clk);
        cs_n = cs; chan_sel = ch; addr = a; bus_din = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        model_write(cs, ch, a, d);
    endtask

    task automatic bus_read(input logic cs, input logic ch, input logic [2:0] a,
                            input string req);
        @(negedge clk);
        cs_n = cs; chan_sel = ch; addr = a; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        if (!cs) begin
            check({req, " oe"}, {7'd0, bus_oe}, 8'h01);
            check({req, " data"}, bus_dout, mdl[idx_of(ch)][a]);
        end else begin
            check({req, " oe released"}, {7'd0, bus_oe}, 8'h00);
        end
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 oe after read", {7'd0, bus_oe}, 8'h00);
    endtask

    task automatic check_status(input string req);
        @(negedge clk);
        check({req, " irq_a"}, {7'd0, irq_a}, {7'd0, exp_irq(0, irq_stat_a)});
        check({req, " irq_b"}, {7'd0, irq_b}, {7'd0, exp_irq(1, irq_stat_b)});
        check({req, " txrdy_n_a"}, {7'd0, txrdy_n_a}, {7'd0, !tx_ready_a});
        check({req, " txrdy_n_b"}, {7'd0, txrdy_n_b}, {7'd0, !tx_ready_b});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int c = 0; c < 2; c++) for (int r = 0; r < 8; r++) mdl[c][r] = '0;
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 irq_a", {7'd0, irq_a}, 8'h00);
        check("R11 irq_b", {7'd0, irq_b}, 8'h00);
        check("R11 txrdy_n_a", {7'd0, txrdy_n_a}, 8'h00);
        check("R11 txrdy_n_b", {7'd0, txrdy_n_b}, 8'h00);
        check("R11 oe", {7'd0, bus_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            bus_read(1'b0, 1'b1, 3'(r), "R11 A reg");
            bus_read(1'b0, 1'b0, 3'(r), "R11 B reg");
        end

        // R1 / R4: distinct values in every register of both channels
        for (int r = 0; r < 8; r++) begin
            bus_write(1'b0, 1'b1, 3'(r), 8'(8'hA0 + r * 2));
            bus_write(1'b0, 1'b0, 3'(r), 8'(8'h30 + r * 4));
        end
        for (int r = 0; r < 8; r++) begin
            bus_read(1'b0, 1'b1, 3'(r), "R1 R4 A");
            bus_read(1'b0, 1'b0, 3'(r), "R1 R4 B");
        end

        // R3: write with chip select high is ignored; R5: read with cs high
        bus_write(1'b1, 1'b1, 3'd2, 8'hEE);
        bus_write(1'b1, 1'b0, 3'd2, 8'hEE);
        bus_read(1'b0, 1'b1, 3'd2, "R3 A");
        bus_read(1'b0, 1'b0, 3'd2, "R3 B");
        bus_read(1'b1, 1'b1, 3'd2, "R5 cs high");

        // R2: no commit while wr_n held low
        bus_write(1'b0, 1'b1, 3'd1, 8'h00);
        irq_stat_a = 4'b0001;
        @(negedge clk);
        cs_n = 1'b0; chan_sel = 1'b1; addr = 3'd1; bus_din = 8'h0F; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 held low irq_a", {7'd0, irq_a}, 8'h00);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        model_write(1'b0, 1'b1, 3'd1, 8'h0F);
        check("R2 after rise irq_a", {7'd0, irq_a}, 8'h01);
        irq_stat_a = 4'b0000;

        // R8 setup: differing values at address 4
        bus_write(1'b0, 1'b1, 3'd4, 8'h11);
        bus_write(1'b0, 1'b0, 3'd4, 8'h22);
        // R6: broadcast enabled through channel A copy
        bus_write(1'b0, 1'b1, 3'd7, 8'h01);
        bus_write(1'b0, 1'b0, 3'd3, 8'h5A);
        bus_read(1'b0, 1'b1, 3'd3, "R6 A copy");
        bus_read(1'b0, 1'b0, 3'd3, "R6 B copy");
        bus_read(1'b0, 1'b1, 3'd4, "R8 A");
        bus_read(1'b0, 1'b0, 3'd4, "R8 B");
        // R7: broadcast clear
        bus_write(1'b0, 1'b0, 3'd7, 8'h00);
        bus_read(1'b0, 1'b1, 3'd7, "R7 A afr");
        bus_read(1'b0, 1'b0, 3'd7, "R7 B afr");
        bus_write(1'b0, 1'b0, 3'd3, 8'h33);
        bus_read(1'b0, 1'b1, 3'd3, "R7 A unicast");
        bus_read(1'b0, 1'b0, 3'd3, "R7 B unicast");
        // R6: broadcast enabled through channel B copy
        bus_write(1'b0, 1'b0, 3'd7, 8'h81);
        bus_write(1'b0, 1'b1, 3'd5, 8'hC3);
        bus_read(1'b0, 1'b0, 3'd5, "R6 B via B afr");
        bus_write(1'b0, 1'b1, 3'd7, 8'h00);

        // R9 / R10 directed
        bus_write(1'b0, 1'b1, 3'd1, 8'h05);
        bus_write(1'b0, 1'b0, 3'd1, 8'h0A);
        irq_stat_a = 4'b0010; irq_stat_b = 4'b0010; tx_ready_a = 1'b1;
        check_status("R9 R10 a");
        irq_stat_a = 4'b0100; irq_stat_b = 4'b0100; tx_ready_b = 1'b1; tx_ready_a = 1'b0;
        check_status("R9 R10 b");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 3));
            logic ch = 1'($urandom);
            logic [2:0] a = 3'($urandom);
            if (op == 0) begin
                bus_write(($urandom_range(0, 3) == 0), ch, a, 8'($urandom));
            end else if (op == 1) begin
                bus_read(($urandom_range(0, 4) == 0), ch, a, "R1 R8 random read");
            end else begin
                irq_stat_a = 4'($urandom); irq_stat_b = 4'($urandom);
                tx_ready_a = 1'($urandom); tx_ready_b = 1'($urandom);
                check_status("R9 R10 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule